// File: doc/BRIEF.md
# Polyphase FIR Convolution Sequencer

This block computes one interpolation convolution per output sample for a stereo pair. On a start strobe it takes a history-RAM start address and a coefficient-phase start pointer from the rate-tracking loop, plus a phase step size. It walks backwards through the sample history one entry per tap while the coefficient phase moves forwards by the step. Each product goes into one multiply-accumulate unit. The sequence for a channel ends when the coefficient phase pointer rolls over, so the tap count follows from the step and the start phase rather than from a fixed limit.

The left channel is convolved first. The right channel then reloads the same start pointers and reuses the same accumulator. Both rounded and saturated results are presented together with a single-cycle valid pulse. The history RAM and the coefficient ROM are external, and both have a registered read with one cycle of latency. A step of 2^20 gives 64 taps, which is the case when the output rate is at least the input rate. A step scaled by the output-to-input rate ratio gives proportionally more taps when the input rate is higher.

Top module: `polyfir_seq`

## Requirements
- R1: When `start_i` is sampled high while idle, the first read of the left channel presents `ram_ptr_i` on `ram_addr_o` with `ram_ch_o` = 0.
- R2: Each later read of a channel presents a RAM address one lower than the previous read, wrapping modulo 256 (0 is followed by 255).
- R3: The 26-bit phase pointer starts at `rom_ptr_i` and advances by `rom_step_i` per tap. `rom_addr_o` is phase bits [25:14].
- R4: A channel's sequence issues taps until the tap whose phase addition carries out of bit 25; that tap is the last one. With a step of 2^20 and a start phase below 2^20, this gives 64 taps. With a step of 2^19, it gives 128 taps.
- R5: The right channel (`ram_ch_o` = 1) follows the left with the same start addresses and the same tap count. Reads within a channel are issued on consecutive cycles. `valid_o` is high in the cycle after the 2N+2nd rising edge following the start edge, where N is the tap count.
- R6: Each result equals the signed sum of sample times coefficient, shifted right by 23 with round-half-up (add 2^22 first), then saturated to the range -8388608..8388607.
- R7: `valid_o` is high for exactly one cycle per convolution. `left_o` and `right_o` hold their values until the next result.
- R8: A start strobe during a running convolution is ignored: the running result is unchanged. It also sets `overrun_o`, which stays high until reset.
- R9: During and after reset the block is idle: `ram_rd_o`, `valid_o`, `busy_o` and `overrun_o` are 0, and `left_o` and `right_o` are 0.
- R10: The sample and coefficient on `ram_data_i` and `coef_i` are taken one cycle after their addresses are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start of an output-sample convolution |
| ram_ptr_i | input | 8 | History RAM start address |
| rom_ptr_i | input | 26 | Coefficient phase start pointer |
| rom_step_i | input | 26 | Phase step per tap |
| ram_rd_o | output | 1 | Read strobe for RAM and ROM |
| ram_ch_o | output | 1 | Channel of the read, 0 left, 1 right |
| ram_addr_o | output | 8 | History RAM read address |
| rom_addr_o | output | 12 | Coefficient ROM read address |
| ram_data_i | input | 24 | Signed sample, one cycle after address |
| coef_i | input | 24 | Signed coefficient, one cycle after address |
| busy_o | output | 1 | Convolution in progress |
| left_o | output | 24 | Left result |
| right_o | output | 24 | Right result |
| valid_o | output | 1 | One-cycle result strobe |
| overrun_o | output | 1 | Sticky flag for a start that arrived while busy |

## Verification
The assertions rely on `rom_step_i` being nonzero and held steady at the start edge. A zero step would never roll over, and the address-stepping properties would then describe an endless run. They also rely on the RAM and ROM answering with exactly one cycle of latency, since the accumulate enable is a one-cycle delay of the read strobe. The bench drives only nonzero steps of 2^19, 3·2^18 and 2^20. It models both memories as registered reads that follow the design's own address outputs. It raises a second start only while a run is in progress, and only to exercise the ignore path.

// File: rtl/polyfir_pkg.sv
package polyfir_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN_L   = 3'd1,
    ST_DRAIN_L = 3'd2,
    ST_RUN_R   = 3'd3,
    ST_DRAIN_R = 3'd4
  } seq_state_e;
endpackage

// File: rtl/polyfir_addr.sv
module polyfir_addr #(
  parameter int RAM_AW = 8,
  parameter int PH_W   = 26,
  parameter int ROM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              rel_i,
  input  logic              adv_i,
  input  logic [RAM_AW-1:0] ram_ptr_i,
  input  logic [PH_W-1:0]   rom_ptr_i,
  input  logic [PH_W-1:0]   step_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              last_o
);
  logic [RAM_AW-1:0] ram_q, ram_d, ram_base_q, ram_base_d;
  logic [PH_W-1:0]   rom_q, rom_d, rom_base_q, rom_base_d, step_q, step_d;
  logic [PH_W:0]     sum_w;

  assign sum_w = {1'b0, rom_q} + {1'b0, step_q};

  always_comb begin
    ram_d      = ram_q;
    rom_d      = rom_q;
    ram_base_d = ram_base_q;
    rom_base_d = rom_base_q;
    step_d     = step_q;
    if (cap_i) begin
      ram_d      = ram_ptr_i;
      rom_d      = rom_ptr_i;
      ram_base_d = ram_ptr_i;
      rom_base_d = rom_ptr_i;
      step_d     = step_i;
    end else if (rel_i) begin
      ram_d = ram_base_q;
      rom_d = rom_base_q;
    end else if (adv_i) begin
      ram_d = ram_q - RAM_AW'(1);
      rom_d = sum_w[PH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_q      <= '0;
      rom_q      <= '0;
      ram_base_q <= '0;
      rom_base_q <= '0;
      step_q     <= '0;
    end else begin
      ram_q      <= ram_d;
      rom_q      <= rom_d;
      ram_base_q <= ram_base_d;
      rom_base_q <= rom_base_d;
      step_q     <= step_d;
    end
  end

  assign ram_addr_o = ram_q;
  assign rom_addr_o = rom_q[PH_W-1 -: ROM_AW];
  assign last_o     = sum_w[PH_W];

  AST_RAM_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv_i) |-> (ram_q == $past(ram_q) - RAM_AW'(1))); // R2
  AST_ROM_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv_i) |-> (rom_q == PH_W'($past(rom_q) + step_q))); // R3
endmodule

// File: rtl/polyfir_mac.sv
module polyfir_mac #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24,
  parameter int ACC_W  = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int PW    = DATA_W + COEF_W;
  localparam int SHIFT = COEF_W - 1;
  localparam logic signed [ACC_W-1:0] HALF =
    {{(ACC_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] RES_MAX =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] RES_MIN =
    {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0]    prod_w;
  logic signed [ACC_W-1:0] acc_q, acc_nxt, acc_d, rnd_w, shv_w;

  assign prod_w = $signed(sample_i) * $signed(coef_i);

  always_comb begin
    acc_nxt = en_i ? acc_q + {{(ACC_W-PW){prod_w[PW-1]}}, prod_w} : acc_q;
    acc_d   = clr_i ? '0 : acc_nxt;
    rnd_w   = acc_nxt + HALF;
    shv_w   = rnd_w >>> SHIFT;
    if (shv_w > RES_MAX)      res_o = RES_MAX[DATA_W-1:0];
    else if (shv_w < RES_MIN) res_o = RES_MIN[DATA_W-1:0];
    else                      res_o = shv_w[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (en_i || clr_i) acc_q <= acc_d;
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !en_i && $past(clr_i)) |-> (acc_q == '0)); // R6
endmodule

// File: rtl/polyfir_ctrl.sv
module polyfir_ctrl
  import polyfir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic cap_o,
  output logic rel_o,
  output logic adv_o,
  output logic rd_o,
  output logic ch_o,
  output logic mac_en_o,
  output logic mac_clr_o,
  output logic cap_l_o,
  output logic cap_r_o,
  output logic busy_o,
  output logic overrun_o
);
  seq_state_e state_q, state_d;
  logic       tap_v_q, ovr_q, ovr_d;

  always_comb begin
    state_d   = state_q;
    cap_o     = 1'b0;
    rel_o     = 1'b0;
    adv_o     = 1'b0;
    rd_o      = 1'b0;
    ch_o      = 1'b0;
    mac_clr_o = 1'b0;
    cap_l_o   = 1'b0;
    cap_r_o   = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        cap_o     = 1'b1;
        mac_clr_o = 1'b1;
        state_d   = ST_RUN_L;
      end
      ST_RUN_L: begin
        rd_o  = 1'b1;
        adv_o = 1'b1;
        if (last_i) state_d = ST_DRAIN_L;
      end
      ST_DRAIN_L: begin
        cap_l_o   = 1'b1;
        rel_o     = 1'b1;
        mac_clr_o = 1'b1;
        state_d   = ST_RUN_R;
      end
      ST_RUN_R: begin
        rd_o  = 1'b1;
        adv_o = 1'b1;
        ch_o  = 1'b1;
        if (last_i) state_d = ST_DRAIN_R;
      end
      ST_DRAIN_R: begin
        ch_o      = 1'b1;
        cap_r_o   = 1'b1;
        mac_clr_o = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    ovr_d = ovr_q | (start_i && (state_q != ST_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_v_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tap_v_q <= rd_o;
      ovr_q   <= ovr_d;
    end
  end

  assign mac_en_o  = tap_v_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign overrun_o = ovr_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !rd_o); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q); // R8
  AST_LEFT_BEFORE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_o) |-> ($past(state_q) == ST_DRAIN_L)); // R5
endmodule

// File: rtl/polyfir_seq.sv
module polyfir_seq #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24,
  parameter int ACC_W  = 56,
  parameter int RAM_AW = 8,
  parameter int PH_W   = 26,
  parameter int ROM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RAM_AW-1:0] ram_ptr_i,
  input  logic [PH_W-1:0]   rom_ptr_i,
  input  logic [PH_W-1:0]   rom_step_i,
  output logic              ram_rd_o,
  output logic              ram_ch_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [DATA_W-1:0] ram_data_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o,
  output logic              overrun_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              cap_w, rel_w, adv_w, last_w, mac_en_w, mac_clr_w;
  logic              cap_l_w, cap_r_w;
  logic [DATA_W-1:0] res_w, left_q, right_q;
  logic              valid_q, valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  polyfir_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .last_i    (last_w),
    .cap_o     (cap_w),
    .rel_o     (rel_w),
    .adv_o     (adv_w),
    .rd_o      (ram_rd_o),
    .ch_o      (ram_ch_o),
    .mac_en_o  (mac_en_w),
    .mac_clr_o (mac_clr_w),
    .cap_l_o   (cap_l_w),
    .cap_r_o   (cap_r_w),
    .busy_o    (busy_o),
    .overrun_o (overrun_o)
  );

  polyfir_addr #(.RAM_AW(RAM_AW), .PH_W(PH_W), .ROM_AW(ROM_AW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cap_i      (cap_w),
    .rel_i      (rel_w),
    .adv_i      (adv_w),
    .ram_ptr_i  (ram_ptr_i),
    .rom_ptr_i  (rom_ptr_i),
    .step_i     (rom_step_i),
    .ram_addr_o (ram_addr_o),
    .rom_addr_o (rom_addr_o),
    .last_o     (last_w)
  );

  polyfir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_i     (mac_en_w),
    .clr_i    (mac_clr_w),
    .sample_i (ram_data_i),
    .coef_i   (coef_i),
    .res_o    (res_w)
  );

  assign valid_d = cap_r_w;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cap_l_w) left_q  <= res_w;
      if (cap_r_w) right_q <= res_w;
      valid_q <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    valid_q |=> !valid_q); // R7
  AST_LEFT_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_q && !$past(cap_l_w)) |=> $stable(left_q)); // R7
endmodule

// File: tb/polyfir_seq_tb.sv
module polyfir_seq_tb;
  typedef struct packed {
    logic [7:0]  rp;
    logic [25:0] rr;
    logic [25:0] st;
    logic [8:0]  taps;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd200, 26'h0000000, 26'h0100000, 9'd64},
    '{8'd3,   26'h0005A3C, 26'h0100000, 9'd64},
    '{8'd100, 26'h0000000, 26'h0080000, 9'd128},
    '{8'd250, 26'h0012345, 26'h00C0000, 9'd86},
    '{8'd17,  26'h0500000, 26'h0100000, 9'd59},
    '{8'd0,   26'h3F00000, 26'h0100000, 9'd1}
  };

  logic        clk, rst_n, start_i;
  logic [7:0]  ram_ptr_i;
  logic [25:0] rom_ptr_i, rom_step_i;
  logic        ram_rd_o, ram_ch_o, busy_o, valid_o, overrun_o;
  logic [7:0]  ram_addr_o;
  logic [11:0] rom_addr_o;
  logic [23:0] ram_data_i, coef_i, left_o, right_o;

  int checks, errors, mode;
  logic signed [23:0] mem_l [256];
  logic signed [23:0] mem_r [256];
  int n_l, n_r;
  logic [7:0]  fa_l, la_l, fa_r;
  logic [11:0] fr_l, fr_r;

  polyfir_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ram_ptr_i(ram_ptr_i),
    .rom_ptr_i(rom_ptr_i), .rom_step_i(rom_step_i), .ram_rd_o(ram_rd_o),
    .ram_ch_o(ram_ch_o), .ram_addr_o(ram_addr_o), .rom_addr_o(rom_addr_o),
    .ram_data_i(ram_data_i), .coef_i(coef_i), .busy_o(busy_o),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .overrun_o(overrun_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic signed [23:0] coef_of(input logic [11:0] a);
    if (mode == 1) return 24'sd8388607;
    if (mode == 2) return 24'sd4194304;
    return 24'((((int'(a) * 53) % 4096) - 2048) * 200);
  endfunction

  always @(posedge clk) begin
    ram_data_i <= ram_ch_o ? mem_r[ram_addr_o] : mem_l[ram_addr_o];
    coef_i     <= coef_of(rom_addr_o);
  end

  always @(negedge clk) begin
    if (ram_rd_o) begin
      if (!ram_ch_o) begin
        if (n_l == 0) begin fa_l = ram_addr_o; fr_l = rom_addr_o; end
        la_l = ram_addr_o;
        n_l++;
      end else begin
        if (n_r == 0) begin fa_r = ram_addr_o; fr_r = rom_addr_o; end
        n_r++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_mode(input int m);
    mode = m;
    for (int i = 0; i < 256; i++) begin
      case (m)
        1: begin mem_l[i] = 24'sd8388607; mem_r[i] = -24'sd8388608; end
        2: begin mem_l[i] = 24'sd1;       mem_r[i] = -24'sd1; end
        default: begin
          mem_l[i] = 24'((((i * 97) % 1024) - 512) * 1000);
          mem_r[i] = 24'((((i * 31 + 7) % 1024) - 512) * 900);
        end
      endcase
    end
  endtask

  task automatic ref_conv(input bit ch, input vec_t v, output int taps,
                          output logic signed [23:0] res);
    longint acc, r;
    logic [7:0]  ra;
    logic [26:0] ph;
    acc = 0; ra = v.rp; ph = {1'b0, v.rr}; taps = 0;
    for (int k = 0; k < 4096; k++) begin
      acc += longint'(ch ? mem_r[ra] : mem_l[ra]) * longint'(coef_of(ph[25:14]));
      taps++;
      ph = ph + {1'b0, v.st};
      if (ph[26]) break;
      ra = ra - 8'd1;
    end
    r = (acc + 64'sd4194304) >>> 23;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    res = 24'(r);
  endtask

  task automatic run(input vec_t v, input bit intrude, output int lat);
    n_l = 0; n_r = 0; lat = 0;
    ram_ptr_i = v.rp; rom_ptr_i = v.rr; rom_step_i = v.st; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!valid_o && lat < 2000) begin
      if (intrude && lat == 5) begin
        ram_ptr_i = 8'd9; rom_ptr_i = 26'h0200000; rom_step_i = 26'h0080000;
        start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      lat++;
    end
  endtask

  task automatic check_vec(input vec_t v, input bit intrude, input string tag);
    int lat, tl, tr;
    logic signed [23:0] el, er;
    logic [23:0] hl;
    ref_conv(1'b0, v, tl, el);
    ref_conv(1'b1, v, tr, er);
    run(v, intrude, lat);
    chk(int'(v.taps) == tl, {tag, " R4 model tap count"}, tl, v.taps);
    chk(n_l == int'(v.taps), {tag, " R4 left taps"}, n_l, v.taps);
    chk(n_r == int'(v.taps), {tag, " R5 right taps"}, n_r, v.taps);
    chk(fa_l == v.rp, {tag, " R1 first address"}, fa_l, v.rp);
    chk(fr_l == v.rr[25:14], {tag, " R3 first rom address"}, fr_l, v.rr[25:14]);
    chk(la_l == 8'(v.rp - 8'(v.taps - 1)), {tag, " R2 last address"}, la_l,
        8'(v.rp - 8'(v.taps - 1)));
    chk(fa_r == v.rp && fr_r == v.rr[25:14], {tag, " R5 right reload"}, fa_r, v.rp);
    chk(lat == 2 * int'(v.taps) + 2, {tag, " R5 R10 latency"}, lat, 2 * v.taps + 2);
    chk(left_o == el, {tag, " R6 left"}, $signed(left_o), el);
    chk(right_o == er, {tag, " R6 right"}, $signed(right_o), er);
    hl = left_o;
    @(negedge clk);
    chk(!valid_o && left_o == hl, {tag, " R7 pulse and hold"}, valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; n_l = 0; n_r = 0;
    rst_n = 1'b0; start_i = 1'b0; ram_ptr_i = '0; rom_ptr_i = '0; rom_step_i = 26'h0100000;
    set_mode(0);
    repeat (3) @(negedge clk);
    chk(!ram_rd_o && !valid_o && !busy_o && !overrun_o, "R9 reset idle", ram_rd_o, 0);
    chk(left_o == 0 && right_o == 0, "R9 reset results", left_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) check_vec(VECS[i], 1'b0, $sformatf("vec%0d", i));
    chk(!overrun_o, "R8 no overrun yet", overrun_o, 0);

    check_vec(VECS[0], 1'b1, "overrun");
    chk(overrun_o, "R8 overrun set", overrun_o, 1);
    check_vec(VECS[3], 1'b0, "after overrun");
    chk(overrun_o, "R8 overrun sticky", overrun_o, 1);

    set_mode(1);
    check_vec(VECS[0], 1'b0, "saturate");
    chk(left_o == 24'h7FFFFF, "R6 positive saturation", left_o, 24'h7FFFFF);
    chk(right_o == 24'h800000, "R6 negative saturation", right_o, 24'h800000);

    set_mode(2);
    check_vec(VECS[5], 1'b0, "round");
    chk(left_o == 24'd1, "R6 half rounds up", left_o, 1);
    chk(right_o == 24'd0, "R6 minus half rounds up", right_o, 0);

    set_mode(0);
    ram_ptr_i = 8'd40; rom_ptr_i = 26'h0; rom_step_i = 26'h0100000; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ram_rd_o && !busy_o && !valid_o && !overrun_o, "R9 reset mid-run", busy_o, 0);
    chk(left_o == 0 && right_o == 0, "R9 results cleared", left_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_vec(VECS[2], 1'b0, "post reset");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule